// File: doc/BRIEF.md
# Saturating Capacity-Inaccuracy Tracker

This block counts the qualified charge cycles that have passed since the learned battery capacity was last refreshed. Each one-cycle charge strobe adds one to the count. A one-cycle capacity-update strobe returns the count to zero. The counter holds at its ceiling and never wraps. Because of this, a pack that is charged many times without a refresh stays marked as stale. A separate flag rises once the count reaches a lower threshold, which tells the host that the capacity estimate can no longer be trusted.

The surrounding fuel-gauge logic decides which charges qualify and when the learned capacity is rewritten. It signals both events to this block as strobes. The tracker only keeps the count and derives the flag from it.

Top module: `cap_inacc_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 and the flag reads 0 once the edge has passed.
- R2: A `chargeStrobe` pulse with no `updateStrobe` in the same cycle raises the count by exactly one at the next rising edge, provided the count is below 255.
- R3: An `updateStrobe` pulse sets the count to 0 at the next rising edge, whatever its previous value.
- R4: When `chargeStrobe` and `updateStrobe` are both high in one cycle, the update has priority and the count becomes 0.
- R5: At 255 the count saturates. A further charge pulse leaves it at 255 and it never wraps to 0.
- R6: `inaccurateFlag` is 1 exactly when the count is 64 or more. At a count of 63 it reads 0, and at 64 it reads 1.
- R7: The flag clears in the same cycle that an update returns the count to 0, with no extra cycle of delay.
- R8: In a cycle with neither strobe high, the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chargeStrobe | input | 1 | One-cycle pulse for a qualified charge |
| updateStrobe | input | 1 | One-cycle pulse for a learned-capacity refresh |
| chargeCount | output | 8 | Charges since the last refresh, saturating at 255 |
| inaccurateFlag | output | 1 | High when the count is at or above 64 |

## Verification
The bench drives the following input patterns:
- Runs of lone charge pulses mixed with idle cycles. These separate a correct increment from a counter that also moves when no strobe is present.
- A walk across 63 and 64. This pins the flag threshold to one exact value.
- A walk past 255. This shows the difference between saturating and wrapping.
- Update pulses, issued alone and together with a charge, at low counts, just above the threshold and at the ceiling. These expose wrong priority and any lag between the count clearing and the flag falling.

// File: rtl/cap_inacc_pkg.sv
package cap_inacc_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clr;  // return count to zero
    logic inc;  // add one to count
  } capCtrl_t;

endpackage

// File: rtl/cap_inacc_ctrl.sv
module cap_inacc_ctrl
  import cap_inacc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     chargeStrobe,
  input  logic     updateStrobe,
  input  logic     atMax,
  output capCtrl_t ctrlBus
);

  // Update has priority over charge; the increment is also held off at the ceiling
  always_comb begin
    ctrlBus.clr = updateStrobe;
    ctrlBus.inc = chargeStrobe && !updateStrobe && !atMax;
  end

  // R4
  both_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    (chargeStrobe && updateStrobe) |-> (ctrlBus.clr && !ctrlBus.inc));

endmodule

// File: rtl/cap_inacc_dp.sv
module cap_inacc_dp
  import cap_inacc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FLAG_THRESH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  capCtrl_t         ctrlBus,
  output logic [CNT_W-1:0] count,
  output logic             atMax,
  output logic             flag
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(FLAG_THRESH);

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (ctrlBus.clr) count <= '0;
    else if (ctrlBus.inc) count <= count + CNT_W'(1);
  end

  assign atMax = (count == CNT_MAX);
  assign flag  = (count >= THRESH_V);

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlBus.inc && !ctrlBus.clr) |=> (count == $past(count) + CNT_W'(1)));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlBus.clr |=> (count == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (atMax && !ctrlBus.clr) |=> (count == CNT_MAX));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrlBus.inc && !ctrlBus.clr) |=> $stable(count));

endmodule

// File: rtl/cap_inacc_tracker.sv
module cap_inacc_tracker #(
  parameter int CNT_W       = 8,
  parameter int FLAG_THRESH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chargeStrobe,
  input  logic             updateStrobe,
  output logic [CNT_W-1:0] chargeCount,
  output logic             inaccurateFlag
);

  import cap_inacc_pkg::*;

  localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(FLAG_THRESH);

  capCtrl_t ctrlBus;
  logic     atMax;

  cap_inacc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .chargeStrobe (chargeStrobe),
    .updateStrobe (updateStrobe),
    .atMax        (atMax),
    .ctrlBus      (ctrlBus)
  );

  cap_inacc_dp #(
    .CNT_W       (CNT_W),
    .FLAG_THRESH (FLAG_THRESH)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrlBus (ctrlBus),
    .count   (chargeCount),
    .atMax   (atMax),
    .flag    (inaccurateFlag)
  );

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inaccurateFlag) |-> ($past(chargeCount) == THRESH_V - CNT_W'(1)));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    updateStrobe |=> !inaccurateFlag);

endmodule

// File: tb/tb_cap_inacc_tracker.sv
module tb_cap_inacc_tracker;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chargeStrobe = 1'b0;
  logic       updateStrobe = 1'b0;
  logic [7:0] chargeCount;
  logic       inaccurateFlag;

  int checks = 0;
  int fails  = 0;
  int modelCount = 0;
  bit finished = 0;

  typedef struct {
    int    cnt;
    bit    flg;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_inacc_tracker dut (
    .clk            (clk),
    .rst            (rst),
    .chargeStrobe   (chargeStrobe),
    .updateStrobe   (updateStrobe),
    .chargeCount    (chargeCount),
    .inaccurateFlag (inaccurateFlag)
  );

  // Driver: applies one cycle of strobes, models the result, queues the expectation
  task automatic step(input bit chg, input bit upd, input string req);
    expItem_t it;
    @(negedge clk);
    chargeStrobe = chg;
    updateStrobe = upd;
    if (upd)                    modelCount = 0;
    else if (chg && modelCount < 255) modelCount = modelCount + 1;
    @(posedge clk);
    #1;
    chargeStrobe = 1'b0;
    updateStrobe = 1'b0;
    it.cnt = modelCount;
    it.flg = (modelCount >= 64);
    it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: pops expectations at falling edges and compares
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (int'(chargeCount) != it.cnt || inaccurateFlag != it.flg) begin
        fails++;
        $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
                 it.req, chargeCount, inaccurateFlag, it.cnt, it.flg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (chargeCount != 8'd0 || inaccurateFlag != 1'b0) begin
      fails++;
      $display("FAIL R1: count=%0d flag=%0b expected count=0 flag=0",
               chargeCount, inaccurateFlag);
    end

    // R2 single charges, interleaved with idle cycles for R8
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b0, "R2");
      if (i % 3 == 0) step(1'b0, 1'b0, "R8");
    end
    // R3 clear from a low count
    step(1'b0, 1'b1, "R3");
    // R4 both strobes at a nonzero count
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R4");
    step(1'b1, 1'b1, "R4");

    // R6 threshold walk: 63 -> flag 0, 64 -> flag 1
    for (int i = 0; i < 63; i++) step(1'b1, 1'b0, "R6");
    step(1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, "R6");
    // R7 flag falls with the clear
    step(1'b0, 1'b1, "R7");
    // R4 both strobes above threshold
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R4");

    // R5 drive to the ceiling and beyond
    for (int i = 0; i < 255; i++) step(1'b1, 1'b0, "R5");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, "R8");
    // R7 clear from the ceiling
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, "R8");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule